// File: doc/BRIEF.md
# Sector Read DMA Controller

This block sits between a host and a simple word-wide storage read port. The host programs a logical block number and a destination memory address through a four-word register port, then writes a read opcode to the command word. From that point the controller works alone: it fetches the sector one word at a time from the storage side and writes each word into system memory through a request/acknowledge write bus. The destination address advances by one word per beat.

A sector is 512 bytes, so with 32-bit words a transfer is 128 beats. Each beat is a storage fetch followed by a memory write. Each side holds its request until it sees its acknowledge. When the final memory write is acknowledged, the controller leaves the busy state and raises its interrupt line. The line stays high until the host writes a clear bit in the status word. A command that arrives while a transfer is running is dropped, and the running transfer works from its own copies of the block number and the address.

Top module: `sdma_ctrl`

## Requirements
- R1: Register word offsets are fixed: 1 holds the logical block number, 2 the destination address, 3 is status, and 0 is the write-only command word. Offsets 1 and 2 read back their last written value and offset 0 reads zero. Status bit 0 is busy and bit 1 is done; all other status bits read 0.
- R2: A write to offset 0 with bits [7:0] equal to 0x01 while not busy starts a transfer, and status busy reads 1 from the next cycle. Any other opcode value has no effect.
- R3: For word i, `sto_req` stays high with `sto_lba` equal to the programmed block number and `sto_word` equal to i until `sto_ack` is seen. The word on `sto_rdata` in that cycle is the one written to memory.
- R4: A sector is SECTOR_BYTES/4 = 128 beats, in order i = 0..127. Beat i drives `mem_req` with the fetched word i at destination + 4*i, and holds the address and data stable until `mem_ack`. Every fetch comes before its write.
- R5: Destination address bits [1:0] are ignored, so the first beat goes to the address with those bits cleared. Addresses wrap modulo 2^32.
- R6: On the clock edge that takes the last `mem_ack`, busy falls and `irq` rises together.
- R7: `irq` (status done) stays high until a status write with bit 1 set. A status write with bit 1 clear has no effect.
- R8: A command write while busy is ignored. Writes to offsets 1 and 2 while busy update the readable registers but do not change the running transfer.
- R9: If a done-clear write lands in the same cycle as the last `mem_ack`, the completion wins and `irq` stays high.
- R10: After reset `irq` is 0, status and offsets 1 and 2 read 0, and neither request is asserted.
- R11: `sto_req` and `mem_req` are never high together, and neither is high while not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| sto_req | output | 1 | Storage word fetch request |
| sto_lba | output | 32 | Logical block number of the fetch |
| sto_word | output | 7 | Word index inside the sector |
| sto_ack | input | 1 | Storage acknowledge; data valid this cycle |
| sto_rdata | input | 32 | Storage read data |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory write acknowledge |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
Two events can meet in one cycle: the last memory acknowledge, which sets done, and a host write that clears done. The bench forces this meeting. Its memory responder pulses the status clear write on the same cycle it acknowledges beat 127, while the done flag of an earlier transfer is still pending. It then expects `irq` to stay high and status to read done without busy. A per-clock reference model of busy and interrupt, built from the port traffic, judges every cycle around that edge.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_FETCH = 2'd1,
        ENG_STORE = 2'd2
    } eng_state_e;

    localparam logic [7:0] OPC_READ = 8'h01;

    localparam logic [1:0] OFS_CMD  = 2'd0;
    localparam logic [1:0] OFS_LBA  = 2'd1;
    localparam logic [1:0] OFS_DEST = 2'd2;
    localparam logic [1:0] OFS_STAT = 2'd3;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_DONE_BIT = 1;

endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
    import sdma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LBA_W  = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              finish,
    output logic [DATA_W-1:0] rdata,
    output logic              start,
    output logic [LBA_W-1:0]  lba,
    output logic [ADDR_W-1:0] dest,
    output logic              irq
);

    typedef struct packed {
        logic [LBA_W-1:0]  lba;
        logic [ADDR_W-1:0] dest;
        logic              done;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d   = r_q;
        start = wr && (addr == OFS_CMD) && (wdata[7:0] == OPC_READ) && !busy;
        if (wr && (addr == OFS_LBA)) begin
            r_d.lba = wdata[LBA_W-1:0];
        end
        if (wr && (addr == OFS_DEST)) begin
            r_d.dest = wdata[ADDR_W-1:0];
        end
        if (wr && (addr == OFS_STAT) && wdata[STAT_DONE_BIT]) begin
            r_d.done = 1'b0;
        end
        // a finishing transfer overrides a clear in the same cycle
        if (finish) begin
            r_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_LBA:  rdata = DATA_W'(r_q.lba);
            OFS_DEST: rdata = DATA_W'(r_q.dest);
            OFS_STAT: begin
                rdata[STAT_BUSY_BIT] = busy;
                rdata[STAT_DONE_BIT] = r_q.done;
            end
            default:  rdata = '0;
        endcase
    end

    assign lba  = r_q.lba;
    assign dest = r_q.dest;
    assign irq  = r_q.done;

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
    import sdma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int LBA_W  = 32,
    parameter int WORDS  = 128,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LBA_W-1:0]  lba_in,
    input  logic [ADDR_W-1:0] dest_in,
    output logic              sto_req,
    output logic [LBA_W-1:0]  sto_lba,
    output logic [IDX_W-1:0]  sto_word,
    input  logic              sto_ack,
    input  logic [DATA_W-1:0] sto_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              finish
);

    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(DATA_W / 8);
    localparam logic [ADDR_W-1:0] ALIGN_MK = ~(STEP - ADDR_W'(1));
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(WORDS - 1);

    typedef struct packed {
        eng_state_e        st;
        logic [LBA_W-1:0]  lba;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] word;
    } eng_t;

    eng_t e_q, e_d;

    always_comb begin
        e_d    = e_q;
        finish = 1'b0;
        unique case (e_q.st)
            ENG_IDLE: begin
                if (start) begin
                    e_d.st   = ENG_FETCH;
                    e_d.lba  = lba_in;
                    e_d.addr = dest_in & ALIGN_MK;
                    e_d.idx  = '0;
                end
            end
            ENG_FETCH: begin
                if (sto_ack) begin
                    e_d.word = sto_rdata;
                    e_d.st   = ENG_STORE;
                end
            end
            ENG_STORE: begin
                if (mem_ack) begin
                    e_d.addr = e_q.addr + STEP;
                    if (e_q.idx == LAST_IDX) begin
                        e_d.st = ENG_IDLE;
                        finish = 1'b1;
                    end else begin
                        e_d.idx = e_q.idx + IDX_W'(1);
                        e_d.st  = ENG_FETCH;
                    end
                end
            end
            default: e_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign sto_req   = (e_q.st == ENG_FETCH);
    assign sto_lba   = e_q.lba;
    assign sto_word  = e_q.idx;
    assign mem_req   = (e_q.st == ENG_STORE);
    assign mem_addr  = e_q.addr;
    assign mem_wdata = e_q.word;
    assign busy      = (e_q.st != ENG_IDLE);

endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl #(
    parameter int SECTOR_BYTES = 512,
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 32,
    parameter int LBA_W        = 32,
    localparam int WORDS       = SECTOR_BYTES / (DATA_W / 8),
    localparam int IDX_W       = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sto_req,
    output logic [LBA_W-1:0]  sto_lba,
    output logic [IDX_W-1:0]  sto_word,
    input  logic              sto_ack,
    input  logic [DATA_W-1:0] sto_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    output logic              irq
);

    logic              start;
    logic              busy;
    logic              finish;
    logic [LBA_W-1:0]  lba;
    logic [ADDR_W-1:0] dest;

    sdma_regs #(
        .DATA_W(DATA_W),
        .LBA_W (LBA_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .busy  (busy),
        .finish(finish),
        .rdata (reg_rdata),
        .start (start),
        .lba   (lba),
        .dest  (dest),
        .irq   (irq)
    );

    sdma_engine #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .LBA_W (LBA_W),
        .WORDS (WORDS)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .lba_in   (lba),
        .dest_in  (dest),
        .sto_req  (sto_req),
        .sto_lba  (sto_lba),
        .sto_word (sto_word),
        .sto_ack  (sto_ack),
        .sto_rdata(sto_rdata),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_ack  (mem_ack),
        .busy     (busy),
        .finish   (finish)
    );

endmodule

// File: rtl/sdma_checker.sv
module sdma_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              sto_req,
    input logic              sto_ack,
    input logic [IDX_W-1:0]  sto_word,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              irq,
    input logic              busy
);

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[7:0] == 8'h01 && !busy) |=> busy); // R2

    AST_STO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sto_req && !sto_ack) |=> (sto_req && $stable(sto_word))); // R3

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata))); // R4

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R5

    AST_IRQ_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_req && mem_ack)); // R6

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wr && reg_addr == 2'd3 && reg_wdata[1])) |=> irq); // R7

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sto_req && mem_req)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sto_req && !mem_req)); // R11

endmodule

bind sdma_ctrl sdma_checker #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
) u_sdma_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .sto_req  (sto_req),
    .sto_ack  (sto_ack),
    .sto_word (sto_word),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .irq      (irq),
    .busy     (busy)
);

// File: tb/tb_sdma_ctrl.sv
`timescale 1ns/1ps
module tb_sdma_ctrl;

    localparam int WORDS = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        sto_req;
    logic [31:0] sto_lba;
    logic [6:0]  sto_word;
    logic        sto_ack = 1'b0;
    logic [31:0] sto_rdata = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic        irq;

    // host drive, with an injection path used by the memory responder
    logic        h_wr = 1'b0;
    logic [1:0]  h_addr = '0;
    logic [31:0] h_data = '0;
    logic        inj_now = 1'b0;
    logic        inj_arm = 1'b0;

    assign reg_wr    = h_wr | inj_now;
    assign reg_addr  = inj_now ? 2'd3 : h_addr;
    assign reg_wdata = inj_now ? 32'h2 : h_data;

    always #4 clk = ~clk;

    sdma_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sto_req(sto_req), .sto_lba(sto_lba), .sto_word(sto_word),
        .sto_ack(sto_ack), .sto_rdata(sto_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .irq(irq)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int st_lat  = 0;
    int mm_lat  = 0;

    function automatic logic [31:0] pat(input logic [31:0] l, input int i);
        return (l * 32'h0001_0003) ^ (32'(i) * 32'h0101_0101) ^ 32'hC3C3_0000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] sh_lba = '0, sh_dest = '0;
    logic [31:0] exp_lba = '0, exp_base = '0;
    logic        m_busy = 1'b0, m_irq = 1'b0;
    int          beat = 0, beat_err = 0, cyc_err = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_irq = 1'b0; sh_lba = '0; sh_dest = '0;
        end else begin
            logic fin, acc, clr;
            fin = 1'b0;
            if (sto_req && sto_ack) begin
                if (sto_lba !== exp_lba || sto_word !== 7'(beat)) begin
                    beat_err++;
                    $display("mismatch fetch beat %0d lba=%h word=%0d", beat, sto_lba, sto_word);
                end
            end
            if (mem_req && mem_ack) begin
                if (mem_addr !== exp_base + 32'(beat) * 32'd4 || mem_wdata !== pat(exp_lba, beat)) begin
                    beat_err++;
                    $display("mismatch write beat %0d addr=%h data=%h", beat, mem_addr, mem_wdata);
                end
                fin  = (beat == WORDS - 1);
                beat = beat + 1;
            end
            acc = reg_wr && reg_addr == 2'd0 && reg_wdata[7:0] == 8'h01 && !m_busy;
            clr = reg_wr && reg_addr == 2'd3 && reg_wdata[1];
            if (acc) begin
                exp_lba  = sh_lba;
                exp_base = sh_dest & 32'hFFFF_FFFC;
                beat     = 0;
                beat_err = 0;
            end
            if (reg_wr && reg_addr == 2'd1) sh_lba  = reg_wdata;
            if (reg_wr && reg_addr == 2'd2) sh_dest = reg_wdata;
            if (fin) m_busy = 1'b0;
            else if (acc) m_busy = 1'b1;
            if (fin) m_irq = 1'b1;
            else if (clr) m_irq = 1'b0;
        end
    end

    // per-clock comparison of interrupt and request activity
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq !== m_irq) cyc_err++;
            if ((sto_req || mem_req) && !m_busy) cyc_err++;
        end
    end

    // ---------------- storage responder ----------------
    int st_cnt = 0;
    always @(negedge clk) begin
        if (sto_ack) begin
            sto_ack = 1'b0;
        end else if (sto_req) begin
            if (st_cnt >= st_lat) begin
                sto_ack   = 1'b1;
                sto_rdata = pat(sto_lba, int'(sto_word));
                st_cnt    = 0;
            end else begin
                st_cnt++;
            end
        end
    end

    // ---------------- memory responder ----------------
    int mm_cnt = 0;
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            inj_now = 1'b0;
        end else if (mem_req) begin
            if (mm_cnt >= mm_lat) begin
                mem_ack = 1'b1;
                mm_cnt  = 0;
                if (inj_arm && beat == WORDS - 1) inj_now = 1'b1;
            end else begin
                mm_cnt++;
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d cycles expected=<150000", cyc);
            finish_run();
        end
    end

    // ---------------- host tasks ----------------
    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        h_wr = 1'b1; h_addr = a; h_data = d;
        @(negedge clk);
        h_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        h_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle;
        for (int i = 0; i < 20000 && m_busy; i++) @(negedge clk);
    endtask

    task automatic run_sector(input logic [31:0] lba, input logic [31:0] dest, input string req);
        reg_write(2'd1, lba);
        reg_write(2'd2, dest);
        reg_write(2'd0, 32'h1);
        wait_idle();
        @(negedge clk);
        check({req, " beats"}, 32'(beat), 32'(WORDS));
        check({req, " beat errors"}, 32'(beat_err), 32'd0);
    endtask

    logic [31:0] rd;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        reg_read(2'd3, rd); check("R10 status", rd, 32'h0);
        reg_read(2'd1, rd); check("R10 lba reg", rd, 32'h0);
        check("R10 irq", {31'b0, irq}, 32'h0);
        check("R10 requests", {30'b0, sto_req, mem_req}, 32'h0);

        // R1/R2/R3/R4/R6 basic transfer with latencies
        st_lat = 1; mm_lat = 2;
        reg_write(2'd1, 32'd7);
        reg_write(2'd2, 32'h0000_1000);
        reg_read(2'd1, rd); check("R1 lba readback", rd, 32'd7);
        reg_read(2'd2, rd); check("R1 dest readback", rd, 32'h0000_1000);
        reg_read(2'd0, rd); check("R1 cmd reads zero", rd, 32'h0);
        reg_write(2'd0, 32'h1);
        reg_read(2'd3, rd); check("R2 busy after start", rd, 32'h1);
        wait_idle();
        @(negedge clk);
        check("R4 beats", 32'(beat), 32'(WORDS));
        check("R3 R4 beat errors", 32'(beat_err), 32'd0);
        reg_read(2'd3, rd); check("R6 status done not busy", rd, 32'h2);
        check("R6 irq", {31'b0, irq}, 32'h1);

        // R7 sticky interrupt
        repeat (10) @(negedge clk);
        check("R7 irq held", {31'b0, irq}, 32'h1);
        reg_write(2'd3, 32'h1);
        check("R7 clear bit zero no effect", {31'b0, irq}, 32'h1);
        reg_write(2'd3, 32'h2);
        check("R7 irq cleared", {31'b0, irq}, 32'h0);
        reg_read(2'd3, rd); check("R7 status after clear", rd, 32'h0);

        // R2 non-read opcode ignored
        reg_write(2'd0, 32'h2);
        repeat (5) @(negedge clk);
        reg_read(2'd3, rd); check("R2 bad opcode idle", rd, 32'h0);
        check("R2 bad opcode no fetch", {31'b0, sto_req}, 32'h0);

        // R8 command and register writes while busy; R5 unaligned dest
        st_lat = 0; mm_lat = 0;
        reg_write(2'd1, 32'd9);
        reg_write(2'd2, 32'h0000_2003);
        reg_write(2'd0, 32'h1);
        repeat (20) @(negedge clk);
        reg_write(2'd1, 32'd100);
        reg_write(2'd2, 32'h0000_5000);
        reg_write(2'd0, 32'h1);
        wait_idle();
        @(negedge clk);
        check("R8 R5 beats", 32'(beat), 32'(WORDS));
        check("R8 R5 beat errors (lba 9, base 0x2000)", 32'(beat_err), 32'd0);
        reg_read(2'd1, rd); check("R8 lba reg updated", rd, 32'd100);
        reg_write(2'd3, 32'h2);

        // R5 address wrap
        st_lat = 2; mm_lat = 1;
        run_sector(32'd3, 32'hFFFF_FF80, "R5 wrap");

        // R9 clear meets completion; irq of previous transfer still pending
        st_lat = 0; mm_lat = 1;
        inj_arm = 1'b1;
        run_sector(32'd21, 32'h0000_8000, "R9 transfer");
        inj_arm = 1'b0;
        check("R9 irq kept", {31'b0, irq}, 32'h1);
        reg_read(2'd3, rd); check("R9 status done", rd, 32'h2);
        reg_write(2'd3, 32'h2);
        check("R9 clear afterwards", {31'b0, irq}, 32'h0);

        // R6 R7 R11 per-clock model agreement
        check("R6 R7 R11 per-clock errors", 32'(cyc_err), 32'd0);

        finish_run();
    end

endmodule